// File: doc/BRIEF.md
# Registered narrow-to-wide bus exchanger

This block moves data between a narrow port A of N bits and a wide port B made of two N-bit halves, a low half and a high half. Toward B, two narrow words arriving on consecutive clock edges are gathered so that both halves of B change on the same edge. The first word is parked in a staging register while the half-select input is low. It moves into the low-half output register on the edge where the half-select input is high, and the high half loads the word present on A at that same edge. Toward A, the half-select input picks the low or the high half of B, and the chosen half is registered onto A on every edge.

Each three-state port is modelled as a data output plus a drive-enable bit. The drive direction is itself registered, so a turnaround happens only at a clock edge. An active-low enable, applied without a register, releases both ports at once. A synchronous active-high reset clears every data register and points the registered direction toward A.

Top module: `nw_bus_exchanger`

## Requirements
- R1: On a rising edge with `rst_i` high, `a_out`, `bl_out` and `bh_out` become 0 and the registered direction becomes 0 (toward A), so with `drive_n` low `a_en`=1 and `b_en`=0.
- R2: A rising edge with `half_sel`=0 loads `a_in` into the staging register and leaves `bl_out` and `bh_out` unchanged.
- R3: A rising edge with `half_sel`=1 copies the staging register into `bl_out` and loads `a_in` into `bh_out` on that same edge.
- R4: A word presented with `half_sel`=0 followed by a word presented with `half_sel`=1 on the next edge appears as `bl_out`=first word and `bh_out`=second word, both changing on the second edge.
- R5: While `half_sel` stays 1, the staging register keeps its value: each further edge re-copies the same staged word into `bl_out` and reloads `bh_out` from `a_in`.
- R6: Every rising edge out of reset loads `a_out` with `bh_in` when `half_sel`=1 and with `bl_in` when `half_sel`=0.
- R7: `way_b` is sampled on the rising edge; with `drive_n` low, `b_en` equals the sampled value and `a_en` its inverse, and a change on `way_b` between edges does not change either enable.
- R8: While `drive_n` is 1, `a_en` and `b_en` are both 0, with no clock edge needed; the data registers keep loading.
- R9: `a_en` and `b_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all registers capture on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| half_sel | input | 1 | 0: stage word / pick low half; 1: complete pair / pick high half |
| way_b | input | 1 | Direction request, 1 = drive B, 0 = drive A (registered) |
| drive_n | input | 1 | Active-low output enable for both ports |
| a_in | input | N | Narrow port data in |
| bl_in | input | N | Wide port low half data in |
| bh_in | input | N | Wide port high half data in |
| a_out | output | N | Narrow port data out |
| a_en | output | 1 | Narrow port drive enable |
| bl_out | output | N | Wide port low half data out |
| bh_out | output | N | Wide port high half data out |
| b_en | output | 1 | Wide port drive enable (both halves) |

## Verification
A direction turnaround and the completion of a pair can land on the same edge: the edge that samples a new `way_b` is also the `half_sel`=1 edge that loads both halves of B. The bench provokes this by flipping `way_b` on the pair-completing edge and, in a long random run, by changing direction, select and enable freely. A scoreboard model predicts both halves and both enables after each edge, and a check between edges confirms that the enables still follow the old direction until the edge arrives.

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger #(
  parameter int N = 18
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         half_sel,
  input  logic         way_b,
  input  logic         drive_n,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] bl_in,
  input  logic [N-1:0] bh_in,
  output logic [N-1:0] a_out,
  output logic         a_en,
  output logic [N-1:0] bl_out,
  output logic [N-1:0] bh_out,
  output logic         b_en
);

  logic [N-1:0] stage_q;
  logic [N-1:0] lo_q;
  logic [N-1:0] hi_q;
  logic [N-1:0] a_q;
  logic         way_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (half_sel) begin
      lo_q <= stage_q;
      hi_q <= a_in;
    end else begin
      stage_q <= a_in;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_q   <= '0;
      way_q <= 1'b0;
    end else begin
      a_q   <= half_sel ? bh_in : bl_in;
      way_q <= way_b;
    end
  end

  assign a_out  = a_q;
  assign bl_out = lo_q;
  assign bh_out = hi_q;
  assign a_en   = !drive_n && !way_q;
  assign b_en   = !drive_n &&  way_q;

endmodule

// File: rtl/nw_bus_exchanger_chk.sv
module nw_bus_exchanger_chk #(
  parameter int N = 18
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         half_sel,
  input logic         way_b,
  input logic         drive_n,
  input logic [N-1:0] a_in,
  input logic [N-1:0] bl_in,
  input logic [N-1:0] bh_in,
  input logic [N-1:0] a_out,
  input logic         a_en,
  input logic [N-1:0] bl_out,
  input logic [N-1:0] bh_out,
  input logic         b_en
);

  logic [1:0] up;
  always_ff @(posedge clk_i) begin
    if (rst_i) up <= '0;
    else if (up != 2'd3) up <= up + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (a_out == '0 && bl_out == '0 && bh_out == '0 && !b_en));

  // R2
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up != 2'd0 && !half_sel) |=> ($stable(bl_out) && $stable(bh_out)));

  // R3
  hi_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up != 2'd0 && half_sel) |=> bh_out == $past(a_in));

  // R4
  pair_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up == 2'd3 && !half_sel) ##1 half_sel |=> bl_out == $past(a_in, 2));

  // R6
  a_pick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up != 2'd0) |=> a_out == ($past(half_sel) ? $past(bh_in) : $past(bl_in)));

  // R7
  way_reg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up != 2'd0 && !drive_n) |-> b_en == $past(way_b));

  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    drive_n |-> (!a_en && !b_en));

  // R9
  excl_chk: assert property (@(posedge clk_i) !(a_en && b_en));

endmodule

bind nw_bus_exchanger nw_bus_exchanger_chk #(.N(N)) chk_i (.*);

// File: tb/nw_bus_exchanger_tb_top.sv
module nw_bus_exchanger_tb_top;
  localparam int N = 18;

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic half_sel = 1'b0, way_b = 1'b0, drive_n = 1'b0;
  logic [N-1:0] a_in = '0, bl_in = '0, bh_in = '0;
  logic [N-1:0] a_out, bl_out, bh_out;
  logic a_en, b_en;

  always #5 clk_i = ~clk_i;

  nw_bus_exchanger #(.N(N)) dut_i (.*);

  typedef struct {
    logic [N-1:0] a, lo, hi;
    logic ae, be;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  logic [N-1:0] m_stage = '0, m_lo = '0, m_hi = '0, m_a = '0;
  logic m_way = 1'b0;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(input logic r, input logic s, input logic w, input logic dn,
                      input logic [N-1:0] a, input logic [N-1:0] bl,
                      input logic [N-1:0] bh, input string tag);
    exp_t e;
    @(negedge clk_i);
    rst_i = r; half_sel = s; way_b = w; drive_n = dn;
    a_in = a; bl_in = bl; bh_in = bh;
    #1;
    checks++;
    if (a_en !== (!dn && !m_way) || b_en !== (!dn && m_way)) begin
      fails++;
      $display("FAIL R7/R8 pre-edge %s: a_en=%b b_en=%b expected %b %b",
               tag, a_en, b_en, !dn && !m_way, !dn && m_way);
    end
    if (r) begin
      m_stage = '0; m_lo = '0; m_hi = '0; m_a = '0; m_way = 1'b0;
    end else begin
      m_way = w;
      m_a = s ? bh : bl;
      if (s) begin m_lo = m_stage; m_hi = a; end
      else m_stage = a;
    end
    e.a = m_a; e.lo = m_lo; e.hi = m_hi;
    e.ae = !dn && !m_way; e.be = !dn && m_way; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (a_out !== e.a || bl_out !== e.lo || bh_out !== e.hi ||
            a_en !== e.ae || b_en !== e.be || (a_en && b_en)) begin
          fails++;
          $display("FAIL %s: a=%h lo=%h hi=%h ae=%b be=%b expected a=%h lo=%h hi=%h ae=%b be=%b",
                   e.tag, a_out, bl_out, bh_out, a_en, b_en,
                   e.a, e.lo, e.hi, e.ae, e.be);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    report();
  end

  initial begin
    step(1, 0, 0, 0, 18'h11111, 18'h22222, 18'h33333, "R1 reset");
    step(1, 1, 1, 0, 18'h12345, 18'h0aaaa, 18'h15555, "R1 reset hold");
    step(0, 0, 1, 0, 18'h0abcd, 18'h01111, 18'h02222, "R2 stage R7 turn to B");
    step(0, 1, 0, 0, 18'h3fedc, 18'h03333, 18'h04444, "R3 R4 pair with turn to A");
    step(0, 1, 1, 0, 18'h00042, 18'h05555, 18'h06666, "R5 repeat high");
    step(0, 1, 1, 0, 18'h00099, 18'h07777, 18'h08888, "R5 repeat high again");
    step(0, 0, 1, 1, 18'h2aaaa, 18'h09999, 18'h0bbbb, "R8 released R2 stage");
    step(0, 0, 1, 1, 18'h15555, 18'h0cccc, 18'h0dddd, "R2 restage");
    step(0, 1, 1, 0, 18'h3ffff, 18'h0eeee, 18'h0ffff, "R4 pair completes");
    step(0, 0, 0, 0, 18'h00000, 18'h3ffff, 18'h00000, "R6 low half to A");
    step(0, 1, 0, 0, 18'h00001, 18'h00000, 18'h3ffff, "R6 high half to A");
    step(1, 1, 1, 0, 18'h00007, 18'h00008, 18'h00009, "R1 mid-run reset");
    for (int i = 0; i < 200; i++)
      step(0, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
           N'($urandom), N'($urandom), N'($urandom), "R9 random");
    step(0, 0, 0, 0, 18'h0, 18'h0, 18'h0, "drain");
    repeat (3) @(posedge clk_i);
    #3;
    report();
  end
endmodule